// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block serves one channel of a general-purpose timer. It takes the value of an external free-running counter and pairs it with one general register and one I/O pin. A 4-bit mode field in a control register decides how the three interact. The counter, its prescaler and the neighbouring channel are all outside the block and arrive as inputs.

In the compare modes, writing the mode drives a preset initial level onto the pin. After that, each compare match drives the pin low, drives it high or toggles it. Two compare codes keep the pin output disabled but still raise matches. In the capture modes, the counter value is copied into the general register on a selected edge of the synchronized pin. In one group of codes the copy is triggered instead by the count events of a neighbouring channel. Every match or capture sets a sticky event flag, which software clears by writing zero to it.

Top module: `tmr_pin_ctl`

## Requirements
- R1: After synchronous reset, the control, general and status registers read 0, and `pin_out` and `pin_oe` are 0.
- R2: `pin_oe` is 1 only while the mode is 0001, 0010, 0011, 0101, 0110 or 0111. It is 0 for 0000, 0100 and every code with bit 3 set.
- R3: Writing a mode with bit 3 clear loads the pin with that code's bit 2. This gives 0 for 00xx and 1 for 01xx, and the level is visible from the cycle after the write.
- R4: A compare match happens when `cnt_tick` is 1, `cnt_val` equals the general register, and mode bit 3 is 0. On a match, mode bits [1:0] select the pin action: 01 drives 0, 10 drives 1, 11 toggles. The result is visible the cycle after the match.
- R5: If `cnt_tick` is 0, or `cnt_val` differs from the general register, there is no match and neither the pin nor the flag changes.
- R6: Modes 0000 and 0100 keep `pin_oe` at 0 but still set the event flag on a compare match.
- R7: Mode 1000 copies `cnt_val` into the general register on a rising pin edge. The copy happens on the third clock edge after the pin changes: two synchronizer stages plus one edge-detect stage.
- R8: Mode 1001 captures only on a falling pin edge. A rising edge leaves the register unchanged.
- R9: Modes 1010 and 1011 capture on both pin edges.
- R10: Modes 11xx capture on the same edge where `nbr_cnt_evt` is 1 and `nbr_clk_sel` is not 000. With `nbr_clk_sel` at 000 no capture occurs, and pin edges are ignored.
- R11: A match or a capture sets the event flag. Writing 0 to status bit 0 clears the flag, and writing 1 leaves it alone. A set in the same cycle as a clear wins.
- R12: The register map is: address 0 holds the mode in bits [3:0], address 1 is the general register, and address 2 is status with the flag in bit 0. `rd_data` reflects `rd_addr` combinationally, and a bus write to the general register takes priority over a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | WIDTH | Read data |
| cnt_val | input | WIDTH | Counter value |
| cnt_tick | input | 1 | Counter incremented this cycle |
| nbr_cnt_evt | input | 1 | Neighbour channel count event |
| nbr_clk_sel | input | 3 | Neighbour channel prescaler select |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| event_flag | output | 1 | Sticky match/capture flag |

## Verification
Several rules are checked by assertions on every cycle: the initial level loaded on a mode write, the low-drive action on a match, the pin and flag holding when nothing happens, the capture load, the flag set, and the neighbour gate at prescaler select 000. The bench scenarios are needed for the rest. These are the three-cycle capture latency from a pin change, the difference between the edge-selected capture modes, the toggle sequence over repeated matches, and set-over-clear priority on the flag. The bench also covers the register readback.

// File: rtl/tmr_pin_pkg.sv
// Shared constants and mode decoding for the timer pin controller.
// Assumes a 4-bit mode field; bit 3 selects capture over compare.
package tmr_pin_pkg;
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_GR   = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;

    // True for compare modes that drive the pin.
    function automatic logic mode_drives_pin(input logic [3:0] m);
        return !m[3] && (m[1:0] != 2'b00);
    endfunction

    // True for any compare mode (pin driven or not).
    function automatic logic mode_is_compare(input logic [3:0] m);
        return !m[3];
    endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
// Synchronizes the asynchronous pin input and produces one-cycle rise/fall
// pulses. Assumes the pin is low at reset (the chain resets to 0).
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], pin_i};
    end

    assign rise_o =  chain_q[LAST-1] & ~chain_q[LAST];
    assign fall_o = ~chain_q[LAST-1] &  chain_q[LAST];

    // R7: a rise pulse means the history stage holds 1 one cycle later.
    p_rise_history_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> chain_q[LAST]);
    // R8: a fall pulse means the history stage holds 0 one cycle later.
    p_fall_history_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !chain_q[LAST]);
endmodule

// File: rtl/tmr_pin_cmp.sv
// Compare-match detection and pin output level. Assumes the counter
// presents its new value together with a one-cycle tick.
module tmr_pin_cmp
    import tmr_pin_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic             mode_wr_i,
    input  logic [3:0]       mode_new_i,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic [WIDTH-1:0] gr_i,
    output logic             match_o,
    output logic             pin_o,
    output logic             oe_o
);
    logic pin_q;

    assign match_o = mode_is_compare(mode_i) && tick_i && (cnt_i == gr_i);
    assign oe_o    = mode_drives_pin(mode_i);
    assign pin_o   = pin_q;

    // Load the initial level on a mode write, else apply the match action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (mode_wr_i && mode_is_compare(mode_new_i)) begin
            pin_q <= mode_new_i[2];
        end else if (match_o) begin
            case (mode_i[1:0])
                2'b01:   pin_q <= 1'b0;
                2'b10:   pin_q <= 1'b1;
                2'b11:   pin_q <= ~pin_q;
                default: pin_q <= pin_q;
            endcase
        end
    end

    p_init_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && !mode_new_i[3]) |=> (pin_o == $past(mode_new_i[2])));
    p_drive_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && mode_i[1:0] == 2'b01 && !mode_wr_i) |=> !pin_o);
    p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_o && !mode_wr_i) |=> $stable(pin_o));
endmodule

// File: rtl/tmr_pin_cap.sv
// Selects the capture trigger from pin edges or neighbour count events.
// Assumes select 000 means the neighbour runs on the undivided clock.
module tmr_pin_cap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       nbr_evt_i,
    input  logic [2:0] nbr_sel_i,
    output logic       cap_o
);
    // Decode the capture source for the current mode.
    always_comb begin
        cap_o = 1'b0;
        case (mode_i[3:2])
            2'b10: begin
                case (mode_i[1:0])
                    2'b00:   cap_o = rise_i;
                    2'b01:   cap_o = fall_i;
                    default: cap_o = rise_i | fall_i;
                endcase
            end
            2'b11:   cap_o = nbr_evt_i && (nbr_sel_i != 3'b000);
            default: cap_o = 1'b0;
        endcase
    end

    p_nbr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[3:2] == 2'b11 && nbr_sel_i == 3'b000) |-> !cap_o);
    p_no_cap_compare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[3] |-> !cap_o);
endmodule

// File: rtl/tmr_pin_ctl.sv
// Top: register file (mode, general register, status flag) wiring the
// synchronizer, compare and capture logic. Assumes WIDTH >= 4.
module tmr_pin_ctl
    import tmr_pin_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic             nbr_cnt_evt,
    input  logic [2:0]       nbr_clk_sel,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             event_flag
);
    localparam int PAD_CTRL = WIDTH - 4;
    localparam int PAD_STAT = WIDTH - 1;

    logic [3:0]       mode_q;
    logic [WIDTH-1:0] gr_q;
    logic             flag_q;
    logic             wr_mode, wr_gr, wr_stat;
    logic             rise, fall, match, cap;

    assign wr_mode = wr_en && (wr_addr == ADR_CTRL);
    assign wr_gr   = wr_en && (wr_addr == ADR_GR);
    assign wr_stat = wr_en && (wr_addr == ADR_STAT);

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .rise_o(rise), .fall_o(fall)
    );

    tmr_pin_cmp #(.WIDTH(WIDTH)) u_cmp (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .mode_wr_i(wr_mode),
        .mode_new_i(wr_data[3:0]), .tick_i(cnt_tick), .cnt_i(cnt_val),
        .gr_i(gr_q), .match_o(match), .pin_o(pin_out), .oe_o(pin_oe)
    );

    tmr_pin_cap u_cap (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .rise_i(rise), .fall_i(fall),
        .nbr_evt_i(nbr_cnt_evt), .nbr_sel_i(nbr_clk_sel), .cap_o(cap)
    );

    // Mode register written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 4'd0;
        else if (wr_mode) mode_q <= wr_data[3:0];
    end

    // General register: bus write wins over a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)     gr_q <= '0;
        else if (wr_gr) gr_q <= wr_data;
        else if (cap)   gr_q <= cnt_val;
    end

    // Sticky event flag: set beats a write-zero clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_q <= 1'b0;
        else if (match || cap)            flag_q <= 1'b1;
        else if (wr_stat && !wr_data[0])  flag_q <= 1'b0;
    end

    assign event_flag = flag_q;

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            ADR_CTRL: rd_data = {{PAD_CTRL{1'b0}}, mode_q};
            ADR_GR:   rd_data = gr_q;
            ADR_STAT: rd_data = {{PAD_STAT{1'b0}}, flag_q};
            default:  rd_data = '0;
        endcase
    end

    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (match || cap) |=> event_flag);
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !cap && !wr_stat) |=> $stable(event_flag));
    p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !wr_gr) |=> (gr_q == $past(cnt_val)));
    p_oe_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'b00) |-> !pin_oe);
endmodule

// File: tb/tmr_pin_ctl_tb.sv
`timescale 1ns/1ps
module tmr_pin_ctl_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_tick = 1'b0;
    logic         nbr_cnt_evt = 1'b0;
    logic [2:0]   nbr_clk_sel = 3'b000;
    logic         pin_in = 1'b0;
    logic         pin_out, pin_oe, event_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_pin_ctl #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_val(cnt_val), .cnt_tick(cnt_tick), .nbr_cnt_evt(nbr_cnt_evt),
        .nbr_clk_sel(nbr_clk_sel), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .event_flag(event_flag)
    );

    // {code[3:0], oe, initial level, level after one match}
    localparam logic [6:0] TBL [0:7] = '{
        {4'b0000, 1'b0, 1'b0, 1'b0},
        {4'b0001, 1'b1, 1'b0, 1'b0},
        {4'b0010, 1'b1, 1'b0, 1'b1},
        {4'b0011, 1'b1, 1'b0, 1'b1},
        {4'b0100, 1'b0, 1'b1, 1'b1},
        {4'b0101, 1'b1, 1'b1, 1'b0},
        {4'b0110, 1'b1, 1'b1, 1'b1},
        {4'b0111, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [W-1:0] v);
        @(negedge clk);
        cnt_val = v; cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    function automatic logic [W-1:0] rd(input logic [1:0] a);
        rd_addr = a;
        return rd_data;
    endfunction

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [W-1:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // Pin change then wait n clocks; sampled at negedges.
    task automatic pin_edge(input logic lvl, input logic [W-1:0] v, input int n);
        @(negedge clk);
        cnt_val = v; pin_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        read_chk("R1 ctrl", 2'd0, 16'h0);
        read_chk("R1 gr", 2'd1, 16'h0);
        read_chk("R1 stat", 2'd2, 16'h0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);

        // R2 R3 R4 R5 R6: vector table walk over compare modes
        for (int i = 0; i < 8; i++) begin
            logic [6:0] e;
            e = TBL[i];
            wr(2'd0, {12'h0, e[6:3]});
            chk($sformatf("R2 oe code %0d", i), pin_oe, e[2]);
            if (e[2]) chk($sformatf("R3 init code %0d", i), pin_out, e[1]);
            wr(2'd1, 16'h0040 + 16'(i));
            tick(16'h003F + 16'(i));
            chk($sformatf("R5 nomatch flag code %0d", i), event_flag, 0);
            if (e[2]) chk($sformatf("R5 nomatch pin code %0d", i), pin_out, e[1]);
            tick(16'h0040 + 16'(i));
            chk($sformatf("R6 flag code %0d", i), event_flag, 1);
            if (e[2]) chk($sformatf("R4 match pin code %0d", i), pin_out, e[0]);
            wr(2'd2, 16'h0);
            chk($sformatf("R11 clear code %0d", i), event_flag, 0);
        end

        // R4: toggle over repeated matches
        wr(2'd0, 16'h3);
        wr(2'd1, 16'h0005);
        tick(16'h0005); chk("R4 toggle 1", pin_out, 1);
        tick(16'h0005); chk("R4 toggle 2", pin_out, 0);
        // R5: equal value without tick
        @(negedge clk); cnt_val = 16'h0005; @(negedge clk); @(negedge clk);
        chk("R5 no tick pin", pin_out, 0);
        wr(2'd2, 16'h0);
        chk("R5 no tick flag", event_flag, 0);

        // R11: write 1 keeps, set wins over clear
        tick(16'h0005);
        wr(2'd2, 16'h1);
        chk("R11 write one keeps", event_flag, 1);
        wr(2'd2, 16'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0; cnt_val = 16'h0005; cnt_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_tick = 1'b0;
        chk("R11 set beats clear", event_flag, 1);
        wr(2'd2, 16'h0);

        // R7: rising capture with latency
        wr(2'd0, 16'h8);
        wr(2'd1, 16'h0);
        pin_edge(1'b1, 16'h1234, 2);
        read_chk("R7 not yet", 2'd1, 16'h0000);
        @(negedge clk);
        read_chk("R7 captured", 2'd1, 16'h1234);
        chk("R7 flag", event_flag, 1);
        read_chk("R2 oe capture", 2'd0, 16'h8);
        chk("R2 oe off capture", pin_oe, 0);

        // R8: falling only
        wr(2'd0, 16'h9);
        pin_edge(1'b0, 16'h0055, 4);
        read_chk("R8 fall", 2'd1, 16'h0055);
        pin_edge(1'b1, 16'h0077, 4);
        read_chk("R8 rise ignored", 2'd1, 16'h0055);

        // R9: both edges
        wr(2'd0, 16'hA);
        pin_edge(1'b0, 16'h00A0, 4);
        read_chk("R9 fall", 2'd1, 16'h00A0);
        pin_edge(1'b1, 16'h00B0, 4);
        read_chk("R9 rise", 2'd1, 16'h00B0);

        // R10: neighbour source
        wr(2'd0, 16'hC);
        wr(2'd2, 16'h0);
        @(negedge clk); nbr_clk_sel = 3'b000; cnt_val = 16'h00C0; nbr_cnt_evt = 1'b1;
        @(negedge clk); nbr_cnt_evt = 1'b0;
        read_chk("R10 gated at 000", 2'd1, 16'h00B0);
        chk("R10 gated flag", event_flag, 0);
        @(negedge clk); nbr_clk_sel = 3'b001; cnt_val = 16'h00C1; nbr_cnt_evt = 1'b1;
        @(negedge clk); nbr_cnt_evt = 1'b0;
        read_chk("R10 captured", 2'd1, 16'h00C1);
        pin_edge(1'b0, 16'h00D0, 4);
        read_chk("R10 pin ignored", 2'd1, 16'h00C1);

        // R12: bus write beats capture, readback
        @(negedge clk);
        cnt_val = 16'h00E0; nbr_cnt_evt = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h1111;
        @(negedge clk);
        wr_en = 1'b0; nbr_cnt_evt = 1'b0;
        read_chk("R12 write beats capture", 2'd1, 16'h1111);
        read_chk("R12 ctrl readback", 2'd0, 16'h000C);
        read_chk("R12 stat readback", 2'd2, 16'h0001);
        read_chk("R12 unused addr", 2'd3, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule